// File: doc/BRIEF.md
# Ring Oscillator Cell-Enable Matrix Controller

This block decides how many tri-state inverter cells of a ring oscillator array are switched on. The array has 17 rows of 3 columns. The lower 16 rows form a matrix driven by a pseudo-thermometer row/column code. The top row is kept permanently on, so the ring always has enough drive to oscillate. A loop filter talks to the block in two ways. It can load a coarse value directly. It can also send single-cycle step pulses that move the held code up or down by one cell.

The held code is a saturating count of enabled matrix cells, from 0 to 48. It is decoded into three groups of lines:
- full-row lines, for rows that have every column on;
- a one-hot partial-row line, for the row that is only partly on;
- column lines, which say how many leading columns of that partial row are on.

A cell is on when its full-row line is set, or when its partial-row line and its column line are both set. Adding one to the code therefore adds exactly one cell. Two separate dithering cells are turned on and off by a second pair of fine-path step pulses. Every enable output comes from a register, so it changes on one clock edge.

Top module: `osc_matrix_ctrl`

## Requirements
- R1: After synchronous active-low reset, every full-row, partial-row, column and dither enable is 0.
- R2: In a cycle with `step_up` high, `step_dn` low and `load` low, the code rises by one. The decoded enables show the new code after that clock edge.
- R3: In a cycle with `step_dn` high, `step_up` low and `load` low, the code falls by one. The decoded enables show the new code after that clock edge.
- R4: If `step_up` and `step_dn` are both high and `load` is low, the code does not change.
- R5: The code saturates at 48. Further up steps leave it at 48, and it never wraps to 0.
- R6: The code saturates at 0. Further down steps leave it at 0, and it never wraps to 48.
- R7: When `load` is high, the code takes the value of `coarse_code`, limited to 48. This overrides any step pulse in the same cycle.
- R8: For code k, let q = k/3 and m = k%3. Bit r of `row_full` (bit 0 = lowest row) is 1 exactly when r < q. `row_part` has only bit q set when m ≠ 0, and is all zero when m = 0. Bit c of `col_en` is 1 exactly when c < m.
- R9: The number of enabled matrix cells, 3·popcount(`row_full`) + popcount(`col_en`), equals the code. A single step therefore changes it by exactly one.
- R10: `row_top_en` is 1 in every cycle, including during reset.
- R11: `dith_up` alone adds one dither cell and `dith_dn` alone removes one. `dith_en` steps through the encodings 2'b00, 2'b01 and 2'b11. It saturates at both ends, and holds when both pulses are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Load `coarse_code` into the code |
| coarse_code | input | 6 | Coarse code value from the loop filter |
| step_up | input | 1 | Overflow pulse; add one cell |
| step_dn | input | 1 | Underflow pulse; remove one cell |
| dith_up | input | 1 | Fine overflow pulse; add one dither cell |
| dith_dn | input | 1 | Fine underflow pulse; remove one dither cell |
| row_full | output | 16 | Rows with all columns enabled |
| row_part | output | 16 | One-hot partly enabled row |
| col_en | output | 3 | Columns enabled in the partial row |
| row_top_en | output | 1 | Permanently enabled 17th row |
| dith_en | output | 2 | Dithering cell enables |

## Verification
A wrong code shows up at once, on the edge after the offending input, as a cell count different from the one the bench tracks. A wrong decode can keep the count right while the cells are wrong. The bench catches this by comparing the full row, partial row and column vectors bit by bit against R8 after every step. The walks go all the way from 0 to 48 and back, so saturation faults and wrap faults show up on the first extra pulse at either end.

// File: rtl/osc_matrix_pkg.sv
// Package: shared sizes for the oscillator matrix controller.
// Assumes a matrix of MTX_ROWS x MTX_COLS cells under pseudo-thermometer control.
package osc_matrix_pkg;
    localparam int MTX_ROWS = 16;
    localparam int MTX_COLS = 3;
    localparam int MTX_CELLS = MTX_ROWS * MTX_COLS;
    localparam int CODE_W = $clog2(MTX_CELLS + 1);
    localparam int DITH_N = 2;

    // Step command decoded from the filter inputs
    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_INC  = 2'b01,
        STEP_DEC  = 2'b10,
        STEP_LOAD = 2'b11
    } step_cmd_e;
endpackage

// File: rtl/osc_code_reg.sv
// Module: osc_code_reg
// Holds the saturating up/down cell code and presents the next code value.
// Assumes single-cycle step pulses. Load has priority over steps, and
// opposing steps cancel.
module osc_code_reg
    import osc_matrix_pkg::*;
#(
    parameter int MAX_CODE = MTX_CELLS,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] coarse_code,
    input  logic          step_up,
    input  logic          step_dn,
    output logic [CW-1:0] code_nxt,
    output logic [CW-1:0] code_q
);
    localparam logic [CW-1:0] CMAX = CW'(MAX_CODE);

    step_cmd_e cmd;

    // Purpose: reduce the filter inputs to one command
    always_comb begin
        if (load)                   cmd = STEP_LOAD;
        else if (step_up && !step_dn) cmd = STEP_INC;
        else if (step_dn && !step_up) cmd = STEP_DEC;
        else                        cmd = STEP_HOLD;
    end

    // Purpose: compute the saturated next code
    always_comb begin
        unique case (cmd)
            STEP_LOAD: code_nxt = (coarse_code > CMAX) ? CMAX : coarse_code;
            STEP_INC:  code_nxt = (code_q == CMAX) ? code_q : code_q + 1'b1;
            STEP_DEC:  code_nxt = (code_q == '0) ? code_q : code_q - 1'b1;
            default:   code_nxt = code_q;
        endcase
    end

    // Purpose: hold the code
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_nxt;
    end

    p_code_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        code_q <= CMAX);
    p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && !step_dn && !load && code_q != CMAX) |=> code_q == $past(code_q) + 1'b1);
    p_step_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_dn && !step_up && !load && code_q != '0) |=> code_q == $past(code_q) - 1'b1);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && step_dn && !load) |=> $stable(code_q));
    p_sat_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == CMAX && !load && !step_dn) |=> code_q == CMAX);
    p_sat_bot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == '0 && !load && !step_up) |=> code_q == '0);
endmodule

// File: rtl/osc_ptc_decode.sv
// Module: osc_ptc_decode
// Decodes a cell code into registered full-row, one-hot partial-row and
// column-enable vectors (pseudo-thermometer). Assumes code <= ROWS*COLS.
module osc_ptc_decode
    import osc_matrix_pkg::*;
#(
    parameter int ROWS = MTX_ROWS,
    parameter int COLS = MTX_COLS,
    parameter int CW = CODE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   code_d,
    output logic [ROWS-1:0] row_full,
    output logic [ROWS-1:0] row_part,
    output logic [COLS-1:0] col_en
);
    logic [CW-1:0]   quo;
    logic [CW-1:0]   rem;
    logic [ROWS-1:0] full_d;
    logic [ROWS-1:0] part_d;
    logic [COLS-1:0] col_d;

    // Purpose: split the code into full-row count and partial column count
    always_comb begin
        quo = code_d / CW'(COLS);
        rem = code_d % CW'(COLS);
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        // Purpose: row r is full below the quotient, partial at it
        always_comb begin
            full_d[r] = (quo > CW'(r));
            part_d[r] = (quo == CW'(r)) && (rem != '0);
        end
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        // Purpose: leading columns of the partial row
        always_comb col_d[c] = (rem > CW'(c));
    end

    // Purpose: register all enables so they change on one edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_full <= '0;
            row_part <= '0;
            col_en   <= '0;
        end else begin
            row_full <= full_d;
            row_part <= part_d;
            col_en   <= col_d;
        end
    end

    p_part_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_part));
    p_col_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (row_part == '0) |-> (col_en == '0));
    p_row_therm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((row_full & (row_full + 1'b1)) == '0));
    p_part_above_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((row_part & row_full) == '0) && ((row_part & (row_full + 1'b1)) == row_part));
    p_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (COLS * $countones(row_full) + $countones(col_en)) == int'($past(code_d)));
endmodule

// File: rtl/osc_dither_ctrl.sv
// Module: osc_dither_ctrl
// Thermometer control of the dithering cells from fine-path pulses.
// Assumes single-cycle pulses; opposing pulses cancel; saturates at both ends.
module osc_dither_ctrl
    import osc_matrix_pkg::*;
#(
    parameter int NCELL = DITH_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up,
    input  logic             dn,
    output logic [NCELL-1:0] dith_en
);
    // Purpose: shift a one in to add a cell, shift it out to remove one
    always_ff @(posedge clk) begin
        if (!rst_n)
            dith_en <= '0;
        else if (up && !dn && !dith_en[NCELL-1])
            dith_en <= {dith_en[NCELL-2:0], 1'b1};
        else if (dn && !up && dith_en[0])
            dith_en <= {1'b0, dith_en[NCELL-1:1]};
    end

    p_dith_therm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((dith_en & (dith_en + 1'b1)) == '0));
    p_dith_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (up && dn) |=> $stable(dith_en));
    p_dith_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (up ^ dn) |=> ($countones(dith_en) == $countones($past(dith_en)) + 1
                       || $countones(dith_en) + 1 == $countones($past(dith_en))
                       || $stable(dith_en)));
endmodule

// File: rtl/osc_matrix_ctrl.sv
// Module: osc_matrix_ctrl (top)
// Central oscillator cell controller: saturating code register, pseudo-thermometer
// row/column decoder for the lower rows, always-on top row and dither cells.
// Assumes the loop filter pulses are synchronous to clk.
module osc_matrix_ctrl
    import osc_matrix_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [CODE_W-1:0]   coarse_code,
    input  logic                step_up,
    input  logic                step_dn,
    input  logic                dith_up,
    input  logic                dith_dn,
    output logic [MTX_ROWS-1:0] row_full,
    output logic [MTX_ROWS-1:0] row_part,
    output logic [MTX_COLS-1:0] col_en,
    output logic                row_top_en,
    output logic [DITH_N-1:0]   dith_en
);
    logic [CODE_W-1:0] code_nxt;
    logic [CODE_W-1:0] code_q;

    // Purpose: top row always driven for minimum ring drive
    assign row_top_en = 1'b1;

    osc_code_reg #(.MAX_CODE(MTX_CELLS), .CW(CODE_W)) u_code (
        .clk(clk), .rst_n(rst_n), .load(load), .coarse_code(coarse_code),
        .step_up(step_up), .step_dn(step_dn),
        .code_nxt(code_nxt), .code_q(code_q)
    );

    osc_ptc_decode #(.ROWS(MTX_ROWS), .COLS(MTX_COLS), .CW(CODE_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .code_d(code_nxt),
        .row_full(row_full), .row_part(row_part), .col_en(col_en)
    );

    osc_dither_ctrl #(.NCELL(DITH_N)) u_dith (
        .clk(clk), .rst_n(rst_n), .up(dith_up), .dn(dith_dn), .dith_en(dith_en)
    );

    p_dec_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (MTX_COLS * $countones(row_full) + $countones(col_en)) == int'(code_q));
endmodule

// File: tb/osc_matrix_ctrl_tb.sv
module osc_matrix_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [5:0]  coarse_code = '0;
    logic        step_up = 1'b0, step_dn = 1'b0, dith_up = 1'b0, dith_dn = 1'b0;
    logic [15:0] row_full, row_part;
    logic [2:0]  col_en;
    logic        row_top_en;
    logic [1:0]  dith_en;

    int n_chk = 0;
    int n_bad = 0;
    int exp_code = 0;
    int exp_dith = 0;

    always #5 clk = ~clk;

    osc_matrix_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .load(load), .coarse_code(coarse_code),
        .step_up(step_up), .step_dn(step_dn), .dith_up(dith_up), .dith_dn(dith_dn),
        .row_full(row_full), .row_part(row_part), .col_en(col_en),
        .row_top_en(row_top_en), .dith_en(dith_en)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare the matrix outputs with the R8/R9 decode of exp_code
    task automatic check_decode(input string req);
        logic [15:0] ef, ep;
        logic [2:0]  ec;
        int q = exp_code / 3;
        int m = exp_code % 3;
        for (int r = 0; r < 16; r++) begin
            ef[r] = (r < q);
            ep[r] = (r == q) && (m != 0);
        end
        for (int c = 0; c < 3; c++) ec[c] = (c < m);
        check({req, "/R8 full"}, 64'(row_full), 64'(ef));
        check({req, "/R8 part"}, 64'(row_part), 64'(ep));
        check({req, "/R8 col"}, 64'(col_en), 64'(ec));
        check({req, "/R9 count"}, 64'(3 * $countones(row_full) + $countones(col_en)), 64'(exp_code));
        check({req, "/R10 top"}, 64'(row_top_en), 64'd1);
    endtask

    function automatic logic [1:0] dith_vec(input int n);
        return (n == 0) ? 2'b00 : (n == 1) ? 2'b01 : 2'b11;
    endfunction

    // Apply one cycle of inputs and update the bench model
    task automatic cycle(input bit ld, input int val, input bit up, input bit dn,
                         input bit du, input bit dd);
        @(negedge clk);
        load = ld; coarse_code = 6'(val); step_up = up; step_dn = dn;
        dith_up = du; dith_dn = dd;
        if (ld) exp_code = (val > 48) ? 48 : val;
        else if (up && !dn && exp_code < 48) exp_code++;
        else if (dn && !up && exp_code > 0) exp_code--;
        if (du && !dd && exp_dith < 2) exp_dith++;
        else if (dd && !du && exp_dith > 0) exp_dith--;
        @(posedge clk);
        #1;
        load = 0; step_up = 0; step_dn = 0; dith_up = 0; dith_dn = 0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R10 top in reset", 64'(row_top_en), 64'd1);
        @(negedge clk) rst_n = 1;
        exp_code = 0; exp_dith = 0;
        @(posedge clk); #1;
        check("R1 full", 64'(row_full), 64'd0);
        check("R1 part", 64'(row_part), 64'd0);
        check("R1 col", 64'(col_en), 64'd0);
        check("R1 dith", 64'(dith_en), 64'd0);
    endtask

    task automatic t_walk_up();
        for (int i = 0; i < 48; i++) begin
            cycle(0, 0, 1, 0, 0, 0);
            check_decode("R2 up");
        end
        for (int i = 0; i < 3; i++) begin
            cycle(0, 0, 1, 0, 0, 0);
            check("R5 sat", 64'(3 * $countones(row_full) + $countones(col_en)), 64'd48);
            check_decode("R5 sat");
        end
    endtask

    task automatic t_walk_down();
        for (int i = 0; i < 48; i++) begin
            cycle(0, 0, 0, 1, 0, 0);
            check_decode("R3 down");
        end
        for (int i = 0; i < 3; i++) begin
            cycle(0, 0, 0, 1, 0, 0);
            check("R6 sat", 64'(row_full | row_part | 16'(col_en)), 64'd0);
        end
    endtask

    task automatic t_both();
        cycle(1, 20, 0, 0, 0, 0);
        check_decode("R7 load 20");
        cycle(0, 0, 1, 1, 0, 0);
        check("R4 hold", 64'(3 * $countones(row_full) + $countones(col_en)), 64'd20);
        check_decode("R4 hold");
    endtask

    task automatic t_load();
        int vals[6] = '{7, 30, 63, 0, 49, 45};
        foreach (vals[i]) begin
            cycle(1, vals[i], 0, 0, 0, 0);
            check_decode("R7 load");
        end
        cycle(1, 10, 1, 0, 0, 0);
        check("R7 priority up", 64'(3 * $countones(row_full) + $countones(col_en)), 64'd10);
        cycle(1, 33, 0, 1, 0, 0);
        check("R7 priority dn", 64'(3 * $countones(row_full) + $countones(col_en)), 64'd33);
        check_decode("R7 priority");
    endtask

    task automatic t_dither();
        cycle(0, 0, 0, 0, 0, 1);
        check("R11 floor", 64'(dith_en), 64'(dith_vec(exp_dith)));
        for (int i = 0; i < 3; i++) begin
            cycle(0, 0, 0, 0, 1, 0);
            check("R11 up", 64'(dith_en), 64'(dith_vec(exp_dith)));
        end
        check("R11 top", 64'(dith_en), 64'h3);
        cycle(0, 0, 0, 0, 1, 1);
        check("R11 hold", 64'(dith_en), 64'h3);
        for (int i = 0; i < 3; i++) begin
            cycle(0, 0, 0, 0, 0, 1);
            check("R11 dn", 64'(dith_en), 64'(dith_vec(exp_dith)));
        end
        check("R11 bottom", 64'(dith_en), 64'h0);
        cycle(0, 0, 0, 0, 1, 0);
        check("R11 one", 64'(dith_en), 64'h1);
        check_decode("R11 matrix untouched");
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_walk_up();
        t_walk_down();
        t_both();
        t_load();
        t_dither();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule